// File: doc/BRIEF.md
# Packed Saturating Arithmetic Unit

This block is the 32-bit arithmetic stage for DSP-style instructions. Each accepted operation takes two operand words, a 4-bit operation code and a 5-bit bit-position operand. One cycle later it returns a result word, a per-operation saturation indication and the carry and overflow bits of an add-with-carry. It also keeps a sticky Q flag that records every saturation or signed-overflow event since it was last cleared.

There are several groups of operations:

- **Packed lane operations.** Signed and unsigned saturating add and subtract split the operand words into four byte lanes or two halfword lanes. The unsigned absolute difference works on the four byte lanes.
- **Bit-range saturation.** The first operand is clamped, as a signed or an unsigned value, to the range that the position operand selects.
- **Add-with-carry.** A full 32-bit add with carry-in reports carry-out and signed overflow.
- **Signed add with Q indication.** A 32-bit signed add returns the wrapped sum and reports signed overflow through the saturation output.

Top module: `dsp_sat_alu`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `res_o`, `sat_o`, `cy_o`, `ov_o`, `q_o` and `vld_o` are all zero.
- R2: An operation is accepted in a cycle with `vld_i` high, and its results appear on the outputs after the next rising clock edge with `vld_o` high for one cycle. While `vld_i` is low, `res_o`, `sat_o`, `cy_o` and `ov_o` hold their values and `vld_o` is low.
- R3: Op codes 0 and 4 are the signed saturating add on 8-bit and 16-bit lanes. A lane whose operands share a sign, and whose wrapped sum has the other sign, is clamped and `sat_o` is set. The clamp is 0x80 / 0x8000 when the first operand is negative, and 0x7F / 0x7FFF otherwise.
- R4: Op codes 1 and 5 are the signed saturating subtract on 8-bit and 16-bit lanes. A lane whose operands differ in sign, and whose wrapped difference has a sign unlike the first operand, is clamped by the first operand's sign as in R3, and `sat_o` is set.
- R5: Op codes 2 and 6 are the unsigned saturating add on 8-bit and 16-bit lanes. A lane whose wrapped sum is below its first operand becomes all ones, and `sat_o` is set.
- R6: Op codes 3 and 7 are the unsigned saturating subtract on 8-bit and 16-bit lanes. A lane gives zero when its first operand is at most its second. `sat_o` is set only when the first operand is strictly smaller.
- R7: Lanes are packed little-end first: byte lane k sits at bits 8k+7:8k and halfword lane k at bits 16k+15:16k. No carry passes between lanes, and `sat_o` is the OR of the lane clamps.
- R8: Op code 8 returns, in each byte lane, the larger operand byte minus the smaller one, and never sets `sat_o`.
- R9: Op code 9 is signed saturation of `a_i` at position n = `pos_i`. With t = `a_i` arithmetically shifted right by n, the result is 2^n-1 if t > 0, the complement of 2^n-1 if t < -1, and `a_i` otherwise. `sat_o` is set exactly when a clamp occurs.
- R10: Op code 10 is unsigned saturation of `a_i` at position n. A negative input gives 0, an input above 2^n-1 gives 2^n-1, and either case sets `sat_o`. Any other input passes unchanged with `sat_o` clear.
- R11: Op code 11 returns `a_i + b_i + cin_i` modulo 2^32. `cy_o` is set when the unsigned sum needs 33 bits, and `ov_o` is set when the exact signed sum differs from the signed result. For every other op code, `cy_o` and `ov_o` are zero.
- R12: Op code 12 returns the wrapped sum `a_i + b_i`. `sat_o` is set when both operands share a sign bit and the sum's sign bit differs from the first operand's.
- R13: `q_o` is set after any accepted operation that sets `sat_o`, and stays set until a cycle with `qclr_i` high. That clear takes effect at the next edge and wins over a saturating operation in the same cycle.
- R14: Op codes 13 to 15 are reserved. They give a zero result and clear `sat_o`, `cy_o` and `ov_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Saturation bit position |
| cin_i | input | 1 | Carry-in for add-with-carry |
| qclr_i | input | 1 | Clears the sticky Q flag |
| res_o | output | 32 | Registered result |
| sat_o | output | 1 | Saturation or Q overflow of the last operation |
| cy_o | output | 1 | Carry-out of add-with-carry |
| ov_o | output | 1 | Signed overflow of add-with-carry |
| q_o | output | 1 | Sticky Q flag |
| vld_o | output | 1 | Result valid |

## Verification
The bench drives the signed lane operations at their exact edges, such as 0x7F+0x01, 0x80+0xFF and 0x80-0x01. A design that tested overflow on the second operand's sign, or picked the clamp from the result's sign, would return the wrong extreme value there. Equal operands on the unsigned subtract check that zero comes back without a saturation flag. Lane patterns that would carry across a lane boundary expose a design that adds the whole word.

Range saturation is run at positions 0, 7 and 31 with values just inside and just outside the range. A design that used an off-by-one limit, or compared the unsigned case as signed, would then clamp the wrong value. Add-with-carry runs through the carry-only, overflow-only and both cases with carry-in set. The Q flag is checked for stickiness across non-saturating operations, and for its clear taking priority over a saturating operation in the same cycle.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    typedef enum logic [3:0] {
        OP_SADD8  = 4'd0,
        OP_SSUB8  = 4'd1,
        OP_UADD8  = 4'd2,
        OP_USUB8  = 4'd3,
        OP_SADD16 = 4'd4,
        OP_SSUB16 = 4'd5,
        OP_UADD16 = 4'd6,
        OP_USUB16 = 4'd7,
        OP_ABSD8  = 4'd8,
        OP_SSAT   = 4'd9,
        OP_USAT   = 4'd10,
        OP_ADC    = 4'd11,
        OP_QADD   = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        LM_SADD = 3'd0,
        LM_SSUB = 3'd1,
        LM_UADD = 3'd2,
        LM_USUB = 3'd3,
        LM_ABSD = 3'd4
    } lane_mode_e;

    // Lane mode for the byte-lane unit
    function automatic lane_mode_e byte_mode(alu_op_e op);
        case (op)
            OP_SSUB8: return LM_SSUB;
            OP_UADD8: return LM_UADD;
            OP_USUB8: return LM_USUB;
            OP_ABSD8: return LM_ABSD;
            default:  return LM_SADD;
        endcase
    endfunction

    // Lane mode for the halfword-lane unit
    function automatic lane_mode_e half_mode(alu_op_e op);
        case (op)
            OP_SSUB16: return LM_SSUB;
            OP_UADD16: return LM_UADD;
            OP_USUB16: return LM_USUB;
            default:   return LM_SADD;
        endcase
    endfunction

endpackage

// File: rtl/sat_lane.sv
module sat_lane
    import sat_alu_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  lane_mode_e        mode,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] res,
    output logic              sat
);
    localparam int MSB = LANE_W - 1;
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};

    logic [LANE_W-1:0] sum_w;
    logic [LANE_W-1:0] dif_w;
    logic [LANE_W-1:0] clamp_s;
    logic              ovf;

    always_comb begin
        sum_w   = a + b;
        dif_w   = a - b;
        clamp_s = a[MSB] ? S_MIN : S_MAX;
        ovf     = 1'b0;
        res     = '0;
        case (mode)
            LM_SADD: begin
                ovf = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
                res = ovf ? clamp_s : sum_w;
            end
            LM_SSUB: begin
                ovf = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
                res = ovf ? clamp_s : dif_w;
            end
            LM_UADD: begin
                ovf = (sum_w < a);
                res = ovf ? '1 : sum_w;
            end
            LM_USUB: begin
                ovf = (a < b);
                res = (a <= b) ? '0 : dif_w;
            end
            LM_ABSD: begin
                ovf = 1'b0;
                res = (a > b) ? dif_w : (b - a);
            end
            default: begin
                ovf = 1'b0;
                res = '0;
            end
        endcase
        sat = ovf;
    end

endmodule

// File: rtl/packed_sat.sv
module packed_sat
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  lane_mode_e        mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              sat
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_sat;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sat_lane #(.LANE_W(LANE_W)) u_lane (
            .mode (mode),
            .a    (a[k*LANE_W +: LANE_W]),
            .b    (b[k*LANE_W +: LANE_W]),
            .res  (res[k*LANE_W +: LANE_W]),
            .sat  (lane_sat[k])
        );
    end

    assign sat = |lane_sat;

endmodule

// File: rtl/range_sat.sv
module range_sat #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value,
    input  logic [POS_W-1:0]  pos,
    input  logic              is_signed,
    output logic [DATA_W-1:0] res,
    output logic              sat
);
    logic [DATA_W-1:0]        lim;
    logic signed [DATA_W-1:0] top;

    always_comb begin
        lim = ({{(DATA_W-1){1'b0}}, 1'b1} << pos) - {{(DATA_W-1){1'b0}}, 1'b1};
        top = $signed(value) >>> pos;
        res = value;
        sat = 1'b0;
        if (is_signed) begin
            if (top > 0) begin
                res = lim;
                sat = 1'b1;
            end else if (top < -1) begin
                res = ~lim;
                sat = 1'b1;
            end
        end else begin
            if (value[DATA_W-1]) begin
                res = '0;
                sat = 1'b1;
            end else if (value > lim) begin
                res = lim;
                sat = 1'b1;
            end
        end
    end

endmodule

// File: rtl/carry_add.sv
module carry_add #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cy,
    output logic              ov
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        sum  = wide[MSB:0];
        cy   = wide[DATA_W];
        ov   = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/dsp_sat_alu.sv
module dsp_sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              cin_i,
    input  logic              qclr_i,
    output logic [DATA_W-1:0] res_o,
    output logic              sat_o,
    output logic              cy_o,
    output logic              ov_o,
    output logic              q_o,
    output logic              vld_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              sat;
        logic              cy;
        logic              ov;
        logic              q;
        logic              vld;
    } out_s;

    alu_op_e           op_e;
    logic [DATA_W-1:0] b8_res, h16_res, rng_res, add_sum;
    logic              b8_sat, h16_sat, rng_sat, add_cy, add_ov;
    logic              add_cin;
    out_s              st_d, st_q;

    assign op_e    = alu_op_e'(op_i);
    assign add_cin = (op_e == OP_ADC) ? cin_i : 1'b0;

    packed_sat #(.DATA_W(DATA_W), .LANE_W(8)) u_bytes (
        .mode (byte_mode(op_e)),
        .a    (a_i),
        .b    (b_i),
        .res  (b8_res),
        .sat  (b8_sat)
    );

    packed_sat #(.DATA_W(DATA_W), .LANE_W(16)) u_halves (
        .mode (half_mode(op_e)),
        .a    (a_i),
        .b    (b_i),
        .res  (h16_res),
        .sat  (h16_sat)
    );

    range_sat #(.DATA_W(DATA_W), .POS_W(POS_W)) u_range (
        .value     (a_i),
        .pos       (pos_i),
        .is_signed (op_e == OP_SSAT),
        .res       (rng_res),
        .sat       (rng_sat)
    );

    carry_add #(.DATA_W(DATA_W)) u_add (
        .a   (a_i),
        .b   (b_i),
        .cin (add_cin),
        .sum (add_sum),
        .cy  (add_cy),
        .ov  (add_ov)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.res = '0;
            st_d.sat = 1'b0;
            st_d.cy  = 1'b0;
            st_d.ov  = 1'b0;
            case (op_e)
                OP_SADD8, OP_SSUB8, OP_UADD8, OP_USUB8, OP_ABSD8: begin
                    st_d.res = b8_res;
                    st_d.sat = b8_sat;
                end
                OP_SADD16, OP_SSUB16, OP_UADD16, OP_USUB16: begin
                    st_d.res = h16_res;
                    st_d.sat = h16_sat;
                end
                OP_SSAT, OP_USAT: begin
                    st_d.res = rng_res;
                    st_d.sat = rng_sat;
                end
                OP_ADC: begin
                    st_d.res = add_sum;
                    st_d.cy  = add_cy;
                    st_d.ov  = add_ov;
                end
                OP_QADD: begin
                    st_d.res = add_sum;
                    st_d.sat = add_ov;
                end
                default: begin
                    st_d.res = '0;
                end
            endcase
        end
        if (qclr_i) begin
            st_d.q = 1'b0;
        end else begin
            st_d.q = st_q.q | (vld_i & st_d.sat);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
    assign sat_o = st_q.sat;
    assign cy_o  = st_q.cy;
    assign ov_o  = st_q.ov;
    assign q_o   = st_q.q;
    assign vld_o = st_q.vld;

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vld_i,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              qclr_i,
    input logic [DATA_W-1:0] res_o,
    input logic              sat_o,
    input logic              cy_o,
    input logic              ov_o,
    input logic              q_o,
    input logic              vld_o
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> (!vld_o && $stable(res_o) && $stable(sat_o)));

    a_r5_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && op_i == 4'd2 && b_i == '0) |=> (res_o == $past(a_i) && !sat_o));

    a_r6_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && op_i == 4'd3 && a_i == b_i) |=> (res_o == '0 && !sat_o));

    a_r11_flags_only_adc: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && op_i != 4'd11) |=> (!cy_o && !ov_o));

    a_r13_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !qclr_i) |=> q_o);

    a_r13_q_clear: assert property (@(posedge clk) disable iff (!rst_n)
        qclr_i |=> !q_o);

    a_r13_q_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_o) |-> (sat_o && vld_o));

    a_r14_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && op_i >= 4'd13) |=> (res_o == '0 && !sat_o));

endmodule

bind dsp_sat_alu sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (vld_i),
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .qclr_i (qclr_i),
    .res_o  (res_o),
    .sat_o  (sat_o),
    .cy_o   (cy_o),
    .ov_o   (ov_o),
    .q_o    (q_o),
    .vld_o  (vld_o)
);

// File: tb/dsp_sat_alu_test.sv
module dsp_sat_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [4:0]  pos_i = '0;
    logic        cin_i = 1'b0;
    logic        qclr_i = 1'b0;
    logic [31:0] res_o;
    logic        sat_o, cy_o, ov_o, q_o, vld_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dsp_sat_alu uut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .pos_i(pos_i), .cin_i(cin_i),
        .qclr_i(qclr_i), .res_o(res_o), .sat_o(sat_o), .cy_o(cy_o),
        .ov_o(ov_o), .q_o(q_o), .vld_o(vld_o)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Reference lane model: w = 8 or 16, mode 0 sadd 1 ssub 2 uadd 3 usub 4 absd
    function automatic logic [32:0] m_lanes(int w, int mode, logic [31:0] a, logic [31:0] b);
        logic [31:0] r = '0;
        logic        s = 1'b0;
        longint      mask = (64'd1 << w) - 1;
        longint      smax = (64'd1 << (w - 1)) - 1;
        longint      smin = -(64'd1 << (w - 1));
        for (int k = 0; k < 32 / w; k++) begin
            longint ux = (longint'(a) >> (k * w)) & mask;
            longint uy = (longint'(b) >> (k * w)) & mask;
            longint sx = (ux > smax) ? ux - (mask + 1) : ux;
            longint sy = (uy > smax) ? uy - (mask + 1) : uy;
            longint v = 0;
            case (mode)
                0: v = sx + sy;
                1: v = sx - sy;
                2: v = ux + uy;
                3: v = ux - uy;
                default: v = (ux > uy) ? ux - uy : uy - ux;
            endcase
            if (mode <= 1) begin
                if (v > smax) begin v = smax; s = 1'b1; end
                if (v < smin) begin v = smin; s = 1'b1; end
            end else if (mode == 2) begin
                if (v > mask) begin v = mask; s = 1'b1; end
            end else if (mode == 3) begin
                if (v < 0) begin v = 0; s = 1'b1; end
            end
            r = r | (32'(v & mask) << (k * w));
        end
        return {s, r};
    endfunction

    function automatic logic [32:0] m_range(bit sgn, logic [31:0] a, int n);
        longint sv = longint'($signed(a));
        longint hi = (64'd1 << n) - 1;
        longint lo = -(64'd1 << n);
        if (sgn) begin
            if (sv > hi) return {1'b1, 32'(hi)};
            if (sv < lo) return {1'b1, 32'(lo)};
            return {1'b0, a};
        end
        if (sv < 0) return {1'b1, 32'd0};
        if (sv > hi) return {1'b1, 32'(hi)};
        return {1'b0, a};
    endfunction

    task automatic run(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] n, logic c);
        @(negedge clk);
        vld_i = 1'b1; op_i = op; a_i = a; b_i = b; pos_i = n; cin_i = c;
        @(negedge clk);
        vld_i = 1'b0;
    endtask

    task automatic lane_case(string tag, logic [3:0] op, int w, int mode, logic [31:0] a, logic [31:0] b);
        logic [32:0] e = m_lanes(w, mode, a, b);
        run(op, a, b, 5'd0, 1'b0);
        chk({tag, " res"}, res_o, e[31:0]);
        chk({tag, " sat"}, {31'd0, sat_o}, {31'd0, e[32]});
        chk({tag, " vld"}, {31'd0, vld_o}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 res", res_o, 32'd0);
        chk("R1 flags", {26'd0, sat_o, cy_o, ov_o, q_o, vld_o}, 32'd0);
    endtask

    task automatic t_signed_add();
        lane_case("R3 sadd8 edges", 4'd0, 8, 0, 32'h7F8010F0, 32'h01FF20F0);
        chk("R3 sadd8 hard", res_o, 32'h7F8030E0);
        lane_case("R3 sadd16", 4'd4, 16, 0, 32'h80007FFF, 32'hFFFF0001);
        chk("R3 sadd16 hard", res_o, 32'h80007FFF);
        lane_case("R3 sadd8 none", 4'd0, 8, 0, 32'h01020304, 32'h10203040);
    endtask

    task automatic t_signed_sub();
        lane_case("R4 ssub8", 4'd1, 8, 1, 32'h807F0005, 32'h01FF0106);
        chk("R4 ssub8 hard", res_o, 32'h807FFFFF);
        lane_case("R4 ssub16", 4'd5, 16, 1, 32'h7FFF8000, 32'h80000001);
    endtask

    task automatic t_unsigned();
        lane_case("R5 uadd8", 4'd2, 8, 2, 32'hFF10F001, 32'h0110200F);
        chk("R5 uadd8 hard", res_o, 32'hFF20FF10);
        lane_case("R5 uadd16", 4'd6, 16, 2, 32'hFFFF1234, 32'h00011111);
        lane_case("R6 usub8", 4'd3, 8, 3, 32'h05050510, 32'h05060001);
        chk("R6 usub8 hard", res_o, 32'h0000050F);
        lane_case("R6 usub8 equal", 4'd3, 8, 3, 32'hA5A5A5A5, 32'hA5A5A5A5);
        chk("R6 equal no sat", {31'd0, sat_o}, 32'd0);
        lane_case("R6 usub16", 4'd7, 16, 3, 32'h00108000, 32'h00207FFF);
    endtask

    task automatic t_lanes();
        // carries from a lane must not reach its neighbour
        lane_case("R7 uadd8 isolation", 4'd2, 8, 2, 32'h000000FF, 32'h00000001);
        chk("R7 lane1 untouched", res_o, 32'h000000FF);
        lane_case("R7 sadd16 isolation", 4'd4, 16, 0, 32'h0000FFFF, 32'h00000001);
        chk("R7 halfword wrap", res_o, 32'h00000000);
    endtask

    task automatic t_absd();
        lane_case("R8 absd", 4'd8, 8, 4, 32'h00FF1080, 32'hFF002080);
        chk("R8 absd hard", res_o, 32'hFFFF1000);
    endtask

    task automatic range_case(string tag, bit sgn, logic [31:0] a, int n);
        logic [32:0] e = m_range(sgn, a, n);
        run(sgn ? 4'd9 : 4'd10, a, 32'h0, 5'(n), 1'b0);
        chk({tag, " res"}, res_o, e[31:0]);
        chk({tag, " sat"}, {31'd0, sat_o}, {31'd0, e[32]});
    endtask

    task automatic t_ssat();
        range_case("R9 ssat7 in", 1'b1, 32'h0000007F, 7);
        range_case("R9 ssat7 hi", 1'b1, 32'h00000080, 7);
        range_case("R9 ssat7 lo", 1'b1, 32'hFFFFFF7F, 7);
        range_case("R9 ssat7 minok", 1'b1, 32'hFFFFFF80, 7);
        range_case("R9 ssat0 neg", 1'b1, 32'hFFFFFFFE, 0);
        range_case("R9 ssat0 m1", 1'b1, 32'hFFFFFFFF, 0);
        range_case("R9 ssat31", 1'b1, 32'h80000000, 31);
    endtask

    task automatic t_usat();
        range_case("R10 usat8 in", 1'b0, 32'h000000FF, 8);
        range_case("R10 usat8 hi", 1'b0, 32'h00000100, 8);
        range_case("R10 usat neg", 1'b0, 32'h80000000, 8);
        range_case("R10 usat31", 1'b0, 32'h7FFFFFFF, 31);
        range_case("R10 usat0", 1'b0, 32'h00000001, 0);
    endtask

    task automatic adc_case(string tag, logic [31:0] a, logic [31:0] b, logic c);
        longint u = longint'(a) + longint'(b) + longint'(c);
        longint s = longint'($signed(a)) + longint'($signed(b)) + longint'(c);
        logic [31:0] r = 32'(u);
        run(4'd11, a, b, 5'd0, c);
        chk({tag, " res"}, res_o, r);
        chk({tag, " cy"}, {31'd0, cy_o}, {31'd0, u > 64'hFFFFFFFF});
        chk({tag, " ov"}, {31'd0, ov_o}, {31'd0, s != longint'($signed(r))});
        chk({tag, " sat"}, {31'd0, sat_o}, 32'd0);
    endtask

    task automatic t_adc();
        adc_case("R11 plain", 32'h00001234, 32'h00000001, 1'b1);
        adc_case("R11 carry", 32'hFFFFFFFF, 32'h00000000, 1'b1);
        adc_case("R11 ovf", 32'h7FFFFFFF, 32'h00000000, 1'b1);
        adc_case("R11 both", 32'h80000000, 32'h80000000, 1'b0);
        adc_case("R11 neg ok", 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        lane_case("R11 flags clear after adc", 4'd0, 8, 0, 32'h0, 32'h0);
        chk("R11 cy/ov zero", {30'd0, cy_o, ov_o}, 32'd0);
    endtask

    task automatic t_qadd();
        run(4'd12, 32'h7FFFFFFF, 32'h00000001, 5'd0, 1'b1);
        chk("R12 wrap res", res_o, 32'h80000000);
        chk("R12 sat", {31'd0, sat_o}, 32'd1);
        run(4'd12, 32'h80000000, 32'h7FFFFFFF, 5'd0, 1'b0);
        chk("R12 mixed res", res_o, 32'hFFFFFFFF);
        chk("R12 mixed sat", {31'd0, sat_o}, 32'd0);
    endtask

    task automatic t_q();
        @(negedge clk); qclr_i = 1'b1;
        @(negedge clk); qclr_i = 1'b0;
        chk("R13 cleared", {31'd0, q_o}, 32'd0);
        lane_case("R13 no-sat op", 4'd2, 8, 2, 32'h01010101, 32'h01010101);
        chk("R13 still clear", {31'd0, q_o}, 32'd0);
        lane_case("R13 sat op", 4'd2, 8, 2, 32'hFF000000, 32'h01000000);
        chk("R13 set", {31'd0, q_o}, 32'd1);
        lane_case("R13 later op", 4'd8, 8, 4, 32'h1, 32'h2);
        chk("R13 sticky", {31'd0, q_o}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R13 sticky idle", {31'd0, q_o}, 32'd1);
        @(negedge clk);
        vld_i = 1'b1; op_i = 4'd0; a_i = 32'h7F; b_i = 32'h01; qclr_i = 1'b1;
        @(negedge clk);
        vld_i = 1'b0; qclr_i = 1'b0;
        chk("R13 clear wins", {31'd0, q_o}, 32'd0);
        chk("R13 op still sat", {31'd0, sat_o}, 32'd1);
    endtask

    task automatic t_reserved();
        run(4'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 1'b1);
        chk("R14 op13 res", res_o, 32'd0);
        chk("R14 op13 flags", {29'd0, sat_o, cy_o, ov_o}, 32'd0);
        run(4'd15, 32'h12345678, 32'h1, 5'd0, 1'b0);
        chk("R14 op15 res", res_o, 32'd0);
    endtask

    task automatic t_hold();
        run(4'd11, 32'h0000FFFF, 32'h00000001, 5'd0, 1'b0);
        @(negedge clk);
        a_i = 32'hDEADBEEF; b_i = 32'h11111111; op_i = 4'd0;
        repeat (2) @(negedge clk);
        chk("R2 hold res", res_o, 32'h00010000);
        chk("R2 vld low", {31'd0, vld_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signed_add();
        t_signed_sub();
        t_unsigned();
        t_lanes();
        t_absd();
        t_ssat();
        t_usat();
        t_adc();
        t_qadd();
        t_q();
        t_reserved();
        t_hold();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule